// File: doc/BRIEF.md
# DRAM Power-Up and Refresh Scheduler

This block brings an asynchronous DRAM from power-up to a usable state and then keeps its contents alive. After reset it waits out a start-up interval and issues a burst of warm-up refresh cycles. It then raises `init_done_o` and schedules CAS-before-RAS refreshes at a fixed average rate. That rate is one refresh per `RFSH_INT_CYC` clocks, or eight times slower when the `LOW_POWER` parameter is set.

The block shares the DRAM strobes with an access sequencer. It raises `bus_req_o` whenever it owes a refresh, and it starts a cycle only on a clock edge where `bus_gnt_i` is high and no refresh is in flight. While a cycle runs it asserts `drv_en_o`, drives RAS, CAS and WE itself, and finishes the cycle whatever the grant does. A refresh that falls due while the bus is withheld is recorded in a saturating debt counter. The owed refreshes are issued back to back once the grant returns. The address lines are never driven, because the device steps its own row counter during this kind of refresh.

Top module: `dram_rfsh_ctrl`

## Requirements
- R1: While `rst_ni` is low, `ras_n_o`, `cas_n_o` and `we_n_o` are 1, and `drv_en_o`, `bus_req_o`, `rfsh_pend_o` and `init_done_o` are 0.
- R2: `bus_req_o` and `rfsh_pend_o` stay 0 for the first `STARTUP_CYC - 1` rising edges after reset release and are 1 after edge number `STARTUP_CYC`.
- R3: Exactly `INIT_RFSH` (default 8) refresh cycles run between the end of the start-up wait and the rise of `init_done_o`; once high, `init_done_o` stays high until reset.
- R4: Every refresh cycle has three phases, in this order: `cas_n_o`=0 with `ras_n_o`=1 for `CSR_CYC` clocks, then both at 0 for `RAS_CYC` clocks, then both at 1 for `RP_CYC` clocks, after which `drv_en_o` falls. RAS never falls within `RP_CYC` clocks of its previous rise.
- R5: `we_n_o` is 1 in every clock of every refresh cycle, so a refresh can never be taken as a test-mode entry.
- R6: After initialization, the debt grows by one every `RFSH_INT_CYC` clocks, or every `8*RFSH_INT_CYC` clocks with `LOW_POWER`=1. With the grant held high, consecutive refresh starts are exactly that far apart.
- R7: A refresh starts only on an edge where `bus_gnt_i` is 1. `bus_req_o` is 1 whenever the debt is non-zero or a cycle is in flight, and `drv_en_o`=1 implies `bus_req_o`=1. When `drv_en_o` is 0, `ras_n_o` and `cas_n_o` are 1.
- R8: The debt saturates at `MAX_DEBT` (default 8). Owed refreshes run back to back with one idle clock between the end of one precharge and the next CAS fall.
- R9: An interval expiry and a refresh start on the same edge leave the debt unchanged.
- R10: `rfsh_pend_o` is 1 exactly while the debt is non-zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_gnt_i | input | 1 | Strobes granted to this block |
| bus_req_o | output | 1 | Request for the shared strobes |
| drv_en_o | output | 1 | This block is driving the strobes |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| we_n_o | output | 1 | Write enable, active low, held high |
| init_done_o | output | 1 | Power-up sequence complete |
| rfsh_pend_o | output | 1 | At least one refresh is owed |

## Verification
An interval expiry and a refresh issue can land on the same edge. One adds to the debt and the other takes from it, and saturation may also be in play. The bench withholds the grant until the debt has saturated. It then re-grants one clock before an expiry, so the first issue collides with that expiry and a later one collides with the next. The block must deliver exactly ten back-to-back refreshes before dropping its request. A design that lets either side win the collision, or that loses the expiry at saturation, delivers a different count.

// File: rtl/dram_rfsh_pkg.sv
`timescale 1ns/1ps
package dram_rfsh_pkg;
  typedef enum logic [1:0] {PH_WAIT, PH_INIT, PH_RUN} phase_e;
  typedef enum logic [1:0] {SQ_IDLE, SQ_CSU, SQ_RAS, SQ_PRE} seq_e;

  function automatic int unsigned max2(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/dram_rfsh_timer.sv
`timescale 1ns/1ps
module dram_rfsh_timer
  import dram_rfsh_pkg::*;
#(
  parameter int unsigned STARTUP_CYC = 40000,
  parameter int unsigned INT_CYC     = 3120,
  parameter int unsigned CNT_W       = 16
) (
  input  logic   clk_i,
  input  logic   rst_ni,
  input  phase_e phase_i,
  output logic   start_done_o,
  output logic   tick_o
);
  logic [CNT_W-1:0] cnt_q;

  always_comb begin
    start_done_o = (phase_i == PH_WAIT) && (cnt_q == CNT_W'(STARTUP_CYC - 1));
    tick_o       = (phase_i == PH_RUN)  && (cnt_q == CNT_W'(INT_CYC - 1));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       cnt_q <= '0;
    else if (phase_i == PH_INIT)       cnt_q <= '0;
    else if (start_done_o || tick_o)   cnt_q <= '0;
    else                               cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/dram_rfsh_debt.sv
`timescale 1ns/1ps
module dram_rfsh_debt #(
  parameter int unsigned MAX_DEBT  = 8,
  parameter int unsigned INIT_LOAD = 8,
  parameter int unsigned DEBT_W    = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic inc_i,
  input  logic dec_i,
  output logic nz_o
);
  logic [DEBT_W-1:0] debt_q;

  assign nz_o = (debt_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      debt_q <= '0;
    end else if (load_i) begin
      debt_q <= DEBT_W'(INIT_LOAD);
    end else begin
      unique case ({inc_i, dec_i})
        2'b10:   if (debt_q != DEBT_W'(MAX_DEBT)) debt_q <= debt_q + 1'b1;
        2'b01:   debt_q <= debt_q - 1'b1;
        default: debt_q <= debt_q;  // idle, or expiry and issue cancel
      endcase
    end
  end
endmodule

// File: rtl/dram_rfsh_seq.sv
`timescale 1ns/1ps
module dram_rfsh_seq
  import dram_rfsh_pkg::*;
#(
  parameter int unsigned CSR_CYC = 2,
  parameter int unsigned RAS_CYC = 12,
  parameter int unsigned RP_CYC  = 8,
  parameter int unsigned SEQ_W   = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic ready_o,
  output logic ras_n_o,
  output logic cas_n_o
);
  seq_e             st_q;
  logic [SEQ_W-1:0] cnt_q;

  assign ready_o = (st_q == SQ_IDLE);
  assign ras_n_o = (st_q != SQ_RAS);
  assign cas_n_o = !((st_q == SQ_CSU) || (st_q == SQ_RAS));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= SQ_IDLE;
      cnt_q <= '0;
    end else begin
      unique case (st_q)
        SQ_IDLE: if (start_i) begin
          st_q  <= SQ_CSU;
          cnt_q <= SEQ_W'(CSR_CYC - 1);
        end
        SQ_CSU: if (cnt_q == '0) begin
          st_q  <= SQ_RAS;
          cnt_q <= SEQ_W'(RAS_CYC - 1);
        end else cnt_q <= cnt_q - 1'b1;
        SQ_RAS: if (cnt_q == '0) begin
          st_q  <= SQ_PRE;
          cnt_q <= SEQ_W'(RP_CYC - 1);
        end else cnt_q <= cnt_q - 1'b1;
        SQ_PRE: if (cnt_q == '0) st_q <= SQ_IDLE;
                else cnt_q <= cnt_q - 1'b1;
        default: st_q <= SQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dram_rfsh_ctrl.sv
`timescale 1ns/1ps
module dram_rfsh_ctrl
  import dram_rfsh_pkg::*;
#(
  parameter int unsigned STARTUP_CYC  = 40000,
  parameter int unsigned RFSH_INT_CYC = 3120,
  parameter bit          LOW_POWER    = 1'b0,
  parameter int unsigned INIT_RFSH    = 8,
  parameter int unsigned MAX_DEBT     = 8,
  parameter int unsigned CSR_CYC      = 2,
  parameter int unsigned RAS_CYC      = 12,
  parameter int unsigned RP_CYC       = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bus_gnt_i,
  output logic bus_req_o,
  output logic drv_en_o,
  output logic ras_n_o,
  output logic cas_n_o,
  output logic we_n_o,
  output logic init_done_o,
  output logic rfsh_pend_o
);
  localparam int unsigned INT_EFF = LOW_POWER ? RFSH_INT_CYC * 8 : RFSH_INT_CYC;
  localparam int unsigned CNT_W   = $clog2(max2(STARTUP_CYC, INT_EFF) + 1);
  localparam int unsigned DEBT_W  = $clog2(max2(INIT_RFSH, MAX_DEBT) + 1);
  localparam int unsigned SEQ_W   = $clog2(max2(max2(CSR_CYC, RAS_CYC), RP_CYC) + 1);

  phase_e phase_q;
  logic   start_done, tick, seq_ready, debt_nz, issue;

  dram_rfsh_timer #(
    .STARTUP_CYC(STARTUP_CYC), .INT_CYC(INT_EFF), .CNT_W(CNT_W)
  ) u_timer (
    .clk_i(clk_i), .rst_ni(rst_ni), .phase_i(phase_q),
    .start_done_o(start_done), .tick_o(tick)
  );

  dram_rfsh_debt #(
    .MAX_DEBT(MAX_DEBT), .INIT_LOAD(INIT_RFSH), .DEBT_W(DEBT_W)
  ) u_debt (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(start_done),
    .inc_i(tick), .dec_i(issue), .nz_o(debt_nz)
  );

  dram_rfsh_seq #(
    .CSR_CYC(CSR_CYC), .RAS_CYC(RAS_CYC), .RP_CYC(RP_CYC), .SEQ_W(SEQ_W)
  ) u_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(issue), .ready_o(seq_ready),
    .ras_n_o(ras_n_o), .cas_n_o(cas_n_o)
  );

  assign issue = (phase_q != PH_WAIT) && bus_gnt_i && debt_nz && seq_ready;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) phase_q <= PH_WAIT;
    else begin
      unique case (phase_q)
        PH_WAIT: if (start_done) phase_q <= PH_INIT;
        PH_INIT: if (!debt_nz && seq_ready) phase_q <= PH_RUN;
        default: phase_q <= phase_q;
      endcase
    end
  end

  assign bus_req_o   = (phase_q != PH_WAIT) && (debt_nz || !seq_ready);
  assign drv_en_o    = !seq_ready;
  assign we_n_o      = 1'b1;
  assign init_done_o = (phase_q == PH_RUN);
  assign rfsh_pend_o = debt_nz;
endmodule

// File: rtl/dram_rfsh_chk.sv
`timescale 1ns/1ps
module dram_rfsh_chk #(
  parameter int unsigned RAS_CYC = 12,
  parameter int unsigned RP_CYC  = 8
) (
  input logic clk_i,
  input logic rst_ni,
  input logic bus_gnt_i,
  input logic bus_req_o,
  input logic drv_en_o,
  input logic ras_n_o,
  input logic cas_n_o,
  input logic init_done_o,
  input logic rfsh_pend_o
);
  localparam int unsigned W = $clog2((RAS_CYC > RP_CYC ? RAS_CYC : RP_CYC) + 2);
  logic [W-1:0] lo_cnt, hi_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_cnt <= '0;
      hi_cnt <= '1;
    end else if (!ras_n_o) begin
      hi_cnt <= '0;
      if (lo_cnt != '1) lo_cnt <= lo_cnt + 1'b1;
    end else begin
      lo_cnt <= '0;
      if (hi_cnt != '1) hi_cnt <= hi_cnt + 1'b1;
    end
  end

  a_r4_cas_lead: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ras_n_o) |-> $past(!cas_n_o));
  a_r4_cas_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ras_n_o |-> !cas_n_o);
  a_r4_ras_width: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ras_n_o) |-> (lo_cnt >= W'(RAS_CYC)));
  a_r4_precharge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ras_n_o) |-> (hi_cnt >= W'(RP_CYC)));
  a_r7_idle_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !drv_en_o |-> (ras_n_o && cas_n_o));
  a_r7_req_cover: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drv_en_o |-> bus_req_o);
  a_r7_grant_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(drv_en_o) |-> $past(bus_gnt_i));
  a_r3_done_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_done_o |=> init_done_o);
  a_r10_pend_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rfsh_pend_o |-> bus_req_o);
endmodule

bind dram_rfsh_ctrl dram_rfsh_chk #(.RAS_CYC(RAS_CYC), .RP_CYC(RP_CYC)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .bus_gnt_i(bus_gnt_i), .bus_req_o(bus_req_o),
  .drv_en_o(drv_en_o), .ras_n_o(ras_n_o), .cas_n_o(cas_n_o),
  .init_done_o(init_done_o), .rfsh_pend_o(rfsh_pend_o)
);

// File: tb/dram_rfsh_ctrl_tb_top.sv
`timescale 1ns/1ps
module dram_rfsh_ctrl_tb_top;
  localparam int STARTUP = 100;
  localparam int INTV    = 60;
  localparam int CSR     = 2;
  localparam int RASW    = 4;
  localparam int RP      = 3;

  typedef struct packed {int csu; int ras; int pre;} shape_t;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic gnt = 1'b0;
  logic lp_gnt = 1'b1;
  logic req, drv, ras_n, cas_n, we_n, done, pend;
  logic lp_req, lp_drv, lp_ras_n, lp_cas_n, lp_we_n, lp_done, lp_pend;

  int n_chk = 0, n_fail = 0, cyc = 0, lp_gap = -1;
  bit finished = 1'b0;
  shape_t exp_q[$];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  dram_rfsh_ctrl #(.STARTUP_CYC(STARTUP), .RFSH_INT_CYC(INTV), .LOW_POWER(1'b0),
    .INIT_RFSH(8), .MAX_DEBT(8), .CSR_CYC(CSR), .RAS_CYC(RASW), .RP_CYC(RP)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .bus_gnt_i(gnt), .bus_req_o(req), .drv_en_o(drv),
    .ras_n_o(ras_n), .cas_n_o(cas_n), .we_n_o(we_n), .init_done_o(done), .rfsh_pend_o(pend));

  dram_rfsh_ctrl #(.STARTUP_CYC(STARTUP), .RFSH_INT_CYC(INTV), .LOW_POWER(1'b1),
    .INIT_RFSH(8), .MAX_DEBT(8), .CSR_CYC(CSR), .RAS_CYC(RASW), .RP_CYC(RP)) dut_lp_i (
    .clk_i(clk), .rst_ni(rst_ni), .bus_gnt_i(lp_gnt), .bus_req_o(lp_req), .drv_en_o(lp_drv),
    .ras_n_o(lp_ras_n), .cas_n_o(lp_cas_n), .we_n_o(lp_we_n), .init_done_o(lp_done),
    .rfsh_pend_o(lp_pend));

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  task automatic wait_edges(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic push_shapes(input int n);
    for (int i = 0; i < n; i++) exp_q.push_back('{csu: CSR, ras: RASW, pre: RP});
  endtask

  task automatic wait_rise(output int t);
    logic p;
    p = drv;
    while (1) begin
      @(negedge clk);
      if (drv && !p) break;
      p = drv;
    end
    t = cyc;
  endtask

  task automatic count_until_idle(output int n);
    logic p;
    p = drv;
    n = 0;
    while (1) begin
      @(negedge clk);
      if (drv && !p) n++;
      p = drv;
      if (!req && !drv) break;
    end
  endtask

  // monitor: measures each refresh cycle and compares with the queued expectation
  int m_csu, m_ras, m_pre, m_bad, m_we;
  logic m_prev = 1'b0;
  always @(negedge clk) begin
    if (!rst_ni) begin
      m_prev = 1'b0;
    end else begin
      if (drv && !m_prev) begin
        m_csu = 0; m_ras = 0; m_pre = 0; m_bad = 0; m_we = 0;
      end
      if (drv) begin
        if (!we_n) m_we++;
        if (ras_n && !cas_n)       m_csu++;
        else if (!ras_n && !cas_n) begin m_ras++; if (m_pre != 0) m_bad++; end
        else if (ras_n && cas_n)   m_pre++;
        else                       m_bad++;
        if (ras_n && !cas_n && m_ras != 0) m_bad++;
      end
      if (m_prev && !drv) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R7 unexpected refresh", 1, 0);
        end else begin
          shape_t e;
          e = exp_q.pop_front();
          chk(m_csu == e.csu, "R4 cas lead clocks", m_csu, e.csu);
          chk(m_ras == e.ras, "R4 ras low clocks", m_ras, e.ras);
          chk(m_pre == e.pre, "R4 precharge clocks", m_pre, e.pre);
          chk(m_bad == 0, "R4 phase order", m_bad, 0);
          chk(m_we == 0, "R5 we low during refresh", m_we, 0);
        end
      end
      m_prev = drv;
    end
  end

  // low-power instance: spacing of refreshes after init
  initial begin
    int t0, t1;
    logic p;
    wait (lp_done === 1'b1);
    @(negedge clk);
    p = lp_drv;
    while (1) begin @(negedge clk); if (lp_drv && !p) break; p = lp_drv; end
    t0 = cyc; p = lp_drv;
    while (1) begin @(negedge clk); if (lp_drv && !p) break; p = lp_drv; end
    t1 = cyc;
    lp_gap = t1 - t0;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      chk(1'b0, "watchdog", cyc, 0);
      summary();
      $finish;
    end
  end

  initial begin
    int n, ta, tb, bad;
    repeat (3) @(negedge clk);
    // R1 reset values
    chk(ras_n == 1'b1, "R1 ras_n", ras_n, 1);
    chk(cas_n == 1'b1, "R1 cas_n", cas_n, 1);
    chk(we_n == 1'b1, "R1 we_n", we_n, 1);
    chk(drv == 1'b0, "R1 drv_en", drv, 0);
    chk(req == 1'b0, "R1 bus_req", req, 0);
    chk(pend == 1'b0, "R1 pend", pend, 0);
    chk(done == 1'b0, "R1 init_done", done, 0);
    rst_ni = 1'b1;

    // R2 start-up wait
    wait_edges(STARTUP - 1);
    chk(req == 1'b0, "R2 req before start-up end", req, 0);
    chk(pend == 1'b0, "R2 pend before start-up end", pend, 0);
    wait_edges(1);
    chk(req == 1'b1, "R2 req at start-up end", req, 1);
    chk(pend == 1'b1, "R2 pend at start-up end", pend, 1);
    chk(done == 1'b0, "R3 not done before warm-up", done, 0);

    // R7 nothing runs without grant
    bad = 0;
    repeat (30) begin @(negedge clk); if (drv || !ras_n || !cas_n) bad++; end
    chk(bad == 0, "R7 drive without grant", bad, 0);

    // R3 warm-up burst
    push_shapes(8);
    gnt = 1'b1;
    n = 0;
    begin
      logic p;
      p = drv;
      while (!done) begin @(negedge clk); if (drv && !p) n++; p = drv; end
    end
    chk(n == 8, "R3 warm-up refresh count", n, 8);
    chk(pend == 1'b0, "R10 pend clear after warm-up", pend, 0);

    // R6 steady rate with grant held
    push_shapes(2);
    wait_rise(ta);
    wait_rise(tb);
    chk(tb - ta == INTV, "R6 refresh spacing", tb - ta, INTV);
    gnt = 1'b0;

    // R7/R8 postponed refreshes, debt of three
    wait_edges(20);
    bad = 0;
    repeat (180) begin @(negedge clk); if (drv) bad++; end
    chk(bad == 0, "R7 refresh while grant withheld", bad, 0);
    chk(pend == 1'b1, "R10 pend with debt", pend, 1);
    chk(req == 1'b1, "R7 req with debt", req, 1);
    push_shapes(4);
    gnt = 1'b1;
    count_until_idle(n);
    chk(n == 3, "R8 back-to-back owed refreshes", n, 3);
    chk(pend == 1'b0, "R10 pend clear after drain", pend, 0);

    // R8/R9 saturation plus expiry colliding with issue
    wait_rise(ta);
    gnt = 1'b0;
    wait_edges(658);
    chk(pend == 1'b1, "R10 pend at saturation", pend, 1);
    push_shapes(10);
    gnt = 1'b1;
    count_until_idle(n);
    gnt = 1'b0;
    chk(n == 10, "R9 saturated drain with colliding expiries", n, 10);

    // R6 low-power spacing
    n = 0;
    while (lp_gap < 0 && n < 3000) begin @(negedge clk); n++; end
    chk(lp_gap == 8 * INTV, "R6 low-power spacing", lp_gap, 8 * INTV);

    wait_edges(20);
    chk(exp_q.size() == 0, "R4 expected refreshes all seen", exp_q.size(), 0);
    chk(done == 1'b1, "R3 init_done stays high", done, 1);

    finished = 1'b1;
    summary();
    $finish;
  end
endmodule